// File: doc/BRIEF.md
# Gated-Interval Frequency Counter

This block measures how fast an unknown clock runs by counting its edges over a fixed window timed by a slower, stable reference clock. A free-running counter on the reference clock supplies a gate bit, its most significant bit. One full gate period is 2^GATE_BITS reference cycles. The gate bit is resynchronised into the measured clock's domain. Each rising edge of the gate there ends one counting window and starts the next. The edge count is latched, and the counter restarts in that same cycle. Only a few flops run at the measured clock's rate, so that side can meet timing at hundreds of MHz.

The latched count returns to the reference domain through a toggle handshake. A small state machine handles the return. ST_PRIME waits for the first capture and moves to ST_WAIT without a strobe, because the first window after reset is partial (transition "discard"). ST_WAIT moves to ST_EMIT when it sees the toggle change (transition "accept"), and loads the result register at that point. ST_EMIT lasts one cycle, drives the valid strobe, and always returns to ST_WAIT (transition "release"). An optional fixed prescaler counts only every PRESCALE-th measured edge, and the result is multiplied back by PRESCALE. Resolution is one count per gate period times PRESCALE. A longer gate gives finer steps.

Top module: `freq_gate_counter`

## Requirements
- R1: The reference-domain gate bit is low for 2^(GATE_BITS-1) reference cycles and then high for 2^(GATE_BITS-1) cycles, so successive gate rising edges are exactly 2^GATE_BITS reference cycles apart.
- R2: In the measured domain the gate passes through at least two synchronising flops and one edge-detect flop. Each detected rising edge produces a one-cycle window pulse, which latches the count and restarts counting in the same cycle.
- R3: With PRESCALE = 1, a measured clock locked to the reference gives a result within 1 of 2^GATE_BITS × f_meas / f_ref.
- R4: result_valid is high for exactly one reference cycle per completed window, and strobes are 2^GATE_BITS reference cycles apart while the measured clock is steady.
- R5: The first capture after reset produces no strobe. The first result_valid follows the second gate rising edge after reset, about 3·2^(GATE_BITS-1) reference cycles after reset release.
- R6: result and overflow do not change between strobes.
- R7: The edge counter saturates at 2^CNT_BITS-1. A window that reaches that value reports overflow = 1 with result = (2^CNT_BITS-1) × PRESCALE. Other windows report overflow = 0.
- R8: With PRESCALE > 1, the counter advances once every PRESCALE measured edges, and the result is the count times PRESCALE. The result lies within PRESCALE of the true edge count.
- R9: While rst_n is low, result = 0, overflow = 0 and result_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Stable reference clock; times the gate |
| meas_clk | input | 1 | Clock under measurement |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| result | output | RES_BITS | Scaled edge count of the last full window |
| overflow | output | 1 | Counter saturated during that window |
| result_valid | output | 1 | One-cycle strobe when result updates |

## Verification
The assertions check several properties on every cycle. The gate rising edges are exactly one gate period apart. The measured-domain window pulse and the valid strobe are each one cycle wide. The result and flag stay constant between strobes. A saturated window always reports the scaled maximum. The count values depend on the ratio of the two clocks, so only the bench scenarios can show them: several locked frequency ratios, a prescaled instance, and a forced saturation. The bench scenarios also show that the partial first window is suppressed after reset.

// File: rtl/freq_gate_pkg.sv
package freq_gate_pkg;
    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_WAIT  = 2'd1,
        ST_EMIT  = 2'd2
    } ret_state_e;
endpackage

// File: rtl/fg_gate_gen.sv
module fg_gate_gen #(
    parameter int GATE_BITS = 8
) (
    input  logic ref_clk,
    input  logic rst_n,
    output logic gate
);
    logic [GATE_BITS-1:0] tick_cnt;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) tick_cnt <= '0;
        else        tick_cnt <= tick_cnt + 1'b1;
    end

    assign gate = tick_cnt[GATE_BITS-1];
endmodule

// File: rtl/fg_meas_capture.sv
module fg_meas_capture #(
    parameter int CNT_BITS    = 16,
    parameter int PRESCALE    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                meas_clk,
    input  logic                rst_n,
    input  logic                gate_async,
    output logic [CNT_BITS-1:0] cap_count,
    output logic                cap_ovf,
    output logic                cap_flag,
    output logic                win_pulse
);
    localparam logic [CNT_BITS-1:0] CNT_MAX = '1;

    logic [SYNC_STAGES-1:0] gate_sy;
    logic                   gate_dly;
    logic                   tick;
    logic [CNT_BITS-1:0]    edge_cnt;

    always_ff @(posedge meas_clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_sy  <= '0;
            gate_dly <= 1'b0;
        end else begin
            gate_sy  <= {gate_sy[SYNC_STAGES-2:0], gate_async};
            gate_dly <= gate_sy[SYNC_STAGES-1];
        end
    end

    assign win_pulse = gate_sy[SYNC_STAGES-1] & ~gate_dly;

    generate
        if (PRESCALE > 1) begin : g_div
            localparam int DW = $clog2(PRESCALE);
            localparam logic [DW-1:0] DIV_LAST = DW'(PRESCALE - 1);
            logic [DW-1:0] div_cnt;
            always_ff @(posedge meas_clk or negedge rst_n) begin
                if (!rst_n)                  div_cnt <= '0;
                else if (div_cnt == DIV_LAST) div_cnt <= '0;
                else                         div_cnt <= div_cnt + 1'b1;
            end
            assign tick = (div_cnt == DIV_LAST);
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge meas_clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt  <= '0;
            cap_count <= '0;
            cap_ovf   <= 1'b0;
            cap_flag  <= 1'b0;
        end else if (win_pulse) begin
            cap_count <= edge_cnt;
            cap_ovf   <= (edge_cnt == CNT_MAX);
            cap_flag  <= ~cap_flag;
            edge_cnt  <= CNT_BITS'(tick);
        end else if (tick && edge_cnt != CNT_MAX) begin
            edge_cnt  <= edge_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fg_result_return.sv
module fg_result_return
    import freq_gate_pkg::*;
#(
    parameter int CNT_BITS    = 16,
    parameter int PRESCALE    = 1,
    parameter int RES_BITS    = 17,
    parameter int SYNC_STAGES = 2
) (
    input  logic                ref_clk,
    input  logic                rst_n,
    input  logic [CNT_BITS-1:0] cap_count,
    input  logic                cap_ovf,
    input  logic                cap_flag,
    output logic [RES_BITS-1:0] result,
    output logic                overflow,
    output logic                result_valid
);
    logic [SYNC_STAGES-1:0] flag_sy;
    logic                   flag_seen;
    logic                   flag_change;
    ret_state_e             state, state_nx;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_sy   <= '0;
            flag_seen <= 1'b0;
        end else begin
            flag_sy   <= {flag_sy[SYNC_STAGES-2:0], cap_flag};
            flag_seen <= flag_sy[SYNC_STAGES-1];
        end
    end

    assign flag_change = flag_sy[SYNC_STAGES-1] ^ flag_seen;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PRIME;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PRIME: if (flag_change) state_nx = ST_WAIT;
            ST_WAIT:  if (flag_change) state_nx = ST_EMIT;
            ST_EMIT:  state_nx = ST_WAIT;
            default:  state_nx = ST_PRIME;
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            overflow <= 1'b0;
        end else if (state == ST_WAIT && flag_change) begin
            result   <= RES_BITS'(cap_count) * RES_BITS'(PRESCALE);
            overflow <= cap_ovf;
        end
    end

    always_comb begin
        result_valid = (state == ST_EMIT);
    end
endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter #(
    parameter int GATE_BITS   = 8,
    parameter int CNT_BITS    = 16,
    parameter int PRESCALE    = 1,
    parameter int SYNC_STAGES = 2,
    localparam int RES_BITS   = CNT_BITS + $clog2(PRESCALE + 1)
) (
    input  logic                ref_clk,
    input  logic                meas_clk,
    input  logic                rst_n,
    output logic [RES_BITS-1:0] result,
    output logic                overflow,
    output logic                result_valid
);
    logic                gate_ref;
    logic [CNT_BITS-1:0] cap_count;
    logic                cap_ovf;
    logic                cap_flag;
    logic                win_pulse;

    fg_gate_gen #(.GATE_BITS(GATE_BITS)) u_gate (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .gate    (gate_ref)
    );

    fg_meas_capture #(
        .CNT_BITS(CNT_BITS), .PRESCALE(PRESCALE), .SYNC_STAGES(SYNC_STAGES)
    ) u_capture (
        .meas_clk   (meas_clk),
        .rst_n      (rst_n),
        .gate_async (gate_ref),
        .cap_count  (cap_count),
        .cap_ovf    (cap_ovf),
        .cap_flag   (cap_flag),
        .win_pulse  (win_pulse)
    );

    fg_result_return #(
        .CNT_BITS(CNT_BITS), .PRESCALE(PRESCALE),
        .RES_BITS(RES_BITS), .SYNC_STAGES(SYNC_STAGES)
    ) u_return (
        .ref_clk      (ref_clk),
        .rst_n        (rst_n),
        .cap_count    (cap_count),
        .cap_ovf      (cap_ovf),
        .cap_flag     (cap_flag),
        .result       (result),
        .overflow     (overflow),
        .result_valid (result_valid)
    );
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
    parameter int GATE_BITS = 8,
    parameter int CNT_BITS  = 16,
    parameter int PRESCALE  = 1,
    parameter int RES_BITS  = 17
) (
    input logic                ref_clk,
    input logic                meas_clk,
    input logic                rst_n,
    input logic                gate_ref,
    input logic                win_pulse,
    input logic [RES_BITS-1:0] result,
    input logic                overflow,
    input logic                result_valid
);
    localparam logic [RES_BITS-1:0] SAT_RES =
        RES_BITS'((2 ** CNT_BITS) - 1) * RES_BITS'(PRESCALE);
    localparam logic [GATE_BITS:0] PERIOD = (GATE_BITS + 1)'(2 ** GATE_BITS);

    logic               gate_q;
    logic               seen_rise;
    logic [GATE_BITS:0] span;
    logic               gate_rise;

    assign gate_rise = gate_ref & ~gate_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q    <= 1'b0;
            seen_rise <= 1'b0;
            span      <= '0;
        end else begin
            gate_q <= gate_ref;
            if (gate_rise) begin
                span      <= 1;
                seen_rise <= 1'b1;
            end else begin
                span <= span + 1'b1;
            end
        end
    end

    a_r1_gate_period: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (gate_rise && seen_rise) |-> (span == PERIOD));

    a_r2_window_pulse_single: assert property (@(posedge meas_clk) disable iff (!rst_n)
        win_pulse |=> !win_pulse);

    a_r4_valid_single: assert property (@(posedge ref_clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    a_r6_hold_result: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !result_valid |-> ($stable(result) && $stable(overflow)));

    a_r7_saturated_value: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (result_valid && overflow) |-> (result == SAT_RES));
endmodule

bind freq_gate_counter fg_checker #(
    .GATE_BITS(GATE_BITS), .CNT_BITS(CNT_BITS),
    .PRESCALE(PRESCALE), .RES_BITS(RES_BITS)
) u_fg_checker (
    .ref_clk      (ref_clk),
    .meas_clk     (meas_clk),
    .rst_n        (rst_n),
    .gate_ref     (gate_ref),
    .win_pulse    (win_pulse),
    .result       (result),
    .overflow     (overflow),
    .result_valid (result_valid)
);

// File: tb/test_freq_gate_counter.sv
`timescale 1ns/1ps
module test_freq_gate_counter;
    localparam int GB  = 8;
    localparam int GP  = 2 ** GB;
    localparam int RBA = 16 + 1;
    localparam int RBB = 10 + 3;
    localparam int NV  = 5;
    // meas half period (ps), expected A result, expected B result, expected B overflow
    localparam int HALF_PS [NV] = '{5000, 4000, 2000, 500, 10000};
    localparam int EXP_A   [NV] = '{512, 640, 1280, 5120, 256};
    localparam int EXP_B   [NV] = '{512, 640, 1280, 4092, 256};
    localparam int OVF_B   [NV] = '{0, 0, 0, 1, 0};

    logic ref_clk = 1'b0;
    logic meas_clk = 1'b0;
    logic rst_n = 1'b0;
    real  meas_half = 5.0;

    logic [RBA-1:0] res_a;
    logic           ovf_a, val_a;
    logic [RBB-1:0] res_b;
    logic           ovf_b, val_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 ref_clk = ~ref_clk;
    always #(meas_half) meas_clk = ~meas_clk;

    freq_gate_counter #(.GATE_BITS(GB)) i_freq_gate_counter (
        .ref_clk(ref_clk), .meas_clk(meas_clk), .rst_n(rst_n),
        .result(res_a), .overflow(ovf_a), .result_valid(val_a)
    );

    freq_gate_counter #(.GATE_BITS(GB), .CNT_BITS(10), .PRESCALE(4)) i_freq_gate_counter_div (
        .ref_clk(ref_clk), .meas_clk(meas_clk), .rst_n(rst_n),
        .result(res_b), .overflow(ovf_b), .result_valid(val_b)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic wait_valid(input bit sel_b, output bit got);
        got = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge ref_clk);
            if ((sel_b ? val_b : val_a) === 1'b1) begin
                got = 1;
                break;
            end
        end
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        bit got;
        bit early;
        int gap;
        bit stable_ok;
        logic [RBA-1:0] held;

        // R9: reset values
        repeat (5) @(negedge ref_clk);
        check("R9 result", res_a == 0 && res_b == 0, int'(res_a), 0);
        check("R9 overflow", !ovf_a && !ovf_b, int'(ovf_a), 0);
        check("R9 valid", !val_a && !val_b, int'(val_a), 0);
        rst_n = 1'b1;

        // R5: partial first window produces no strobe
        early = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge ref_clk);
            if (val_a) early = 1;
        end
        check("R5 no strobe for first window", !early, int'(early), 0);
        wait_valid(0, got);
        check("R5 strobe after second gate edge", got, int'(got), 1);
        check("R3 first full window", absdiff(int'(res_a), 512) <= 1, int'(res_a), 512);

        // R4, R1, R6: strobe width, spacing and hold
        @(negedge ref_clk);
        check("R4 strobe one cycle", val_a == 1'b0, int'(val_a), 0);
        held = res_a;
        gap = 1;
        stable_ok = 1;
        while (!val_a && gap < 1000) begin
            if (res_a !== held) stable_ok = 0;
            @(negedge ref_clk);
            gap++;
        end
        check("R4 R1 strobe spacing", gap == GP, gap, GP);
        check("R6 result held between strobes", stable_ok, int'(stable_ok), 1);

        // R3 R7 R8: frequency table
        for (int i = 0; i < NV; i++) begin
            meas_half = HALF_PS[i] / 1000.0;
            wait_valid(0, got);
            wait_valid(0, got);
            wait_valid(0, got);
            check("R3 table result A", got && absdiff(int'(res_a), EXP_A[i]) <= 1,
                  int'(res_a), EXP_A[i]);
            check("R7 no overflow A", got && !ovf_a, int'(ovf_a), 0);
            wait_valid(1, got);
            check("R8 R7 table result B", got && absdiff(int'(res_b), EXP_B[i]) <= 4,
                  int'(res_b), EXP_B[i]);
            check("R7 overflow B", got && (int'(ovf_b) == OVF_B[i]), int'(ovf_b), OVF_B[i]);
        end

        // R7: saturated value exact
        meas_half = 0.5;
        wait_valid(1, got);
        wait_valid(1, got);
        wait_valid(1, got);
        check("R7 saturated result", got && res_b == 4092 && ovf_b, int'(res_b), 4092);

        // R9: reset mid-run clears outputs
        @(negedge ref_clk);
        rst_n = 1'b0;
        @(negedge ref_clk);
        check("R9 mid-run reset", res_a == 0 && res_b == 0 && !ovf_b && !val_a,
              int'(res_b), 0);
        rst_n = 1'b1;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule